// File: doc/BRIEF.md
# Write-Only Voltage-ID Serial Bus Slave

This block receives commands on a two-wire serial bus that sets a supply voltage. The bus has a clock line and an open-drain data line. A faster system clock samples both lines. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds the START and STOP conditions, the rising and falling clock edges, and the data bits. A frame holds an address byte and then one data byte. Each byte is eight bits, most significant bit first, and a ninth clock pulse carries the acknowledge bit. The slave drives the acknowledge by pulling the data line low.

The slave only accepts writes. It answers an address byte only when the top three bits are 110 and the direction bit (bit 0) is 0. When that happens it keeps address bits 4:1. It then acknowledges the data byte that follows. When the acknowledge clock of that byte ends, it pulses a one-cycle strobe. With the strobe it presents data bit 7 as a power-state flag, bits 6:0 as the voltage code, and the four kept address bits. A programming-mode input blocks the acknowledge. A rejected frame is ignored until the next START or STOP.

Top module: `vid_bus_slave`

## Requirements
- R1: After reset the data-line pull (`sda_pull_o`) and the strobe (`upd_o`) are 0, and `psi_o`, `code_o` and `alo_o` are 0.
- R2: An address byte with bits 7:5 equal to 110 and bit 0 equal to 0 is acknowledged: `sda_pull_o` is 1 throughout the high phase of the ninth clock.
- R3: An address byte with a different prefix, or with bit 0 equal to 1, gets no acknowledge. The data byte that follows gets no acknowledge and produces no strobe.
- R4: While `prog_mode_i` is 1 at the address decision, the address is not acknowledged and the frame produces no strobe.
- R5: After an accepted address, the data byte is acknowledged. When the ninth clock falls, `upd_o` pulses for exactly one cycle. With the pulse, `psi_o` = data bit 7, `code_o` = data bits 6:0 and `alo_o` = address bits 4:1.
- R6: Bits are sampled on the rising clock, the first bit received being bit 7 of each byte.
- R7: A STOP in the middle of the data byte discards the partial byte. No strobe occurs, and `psi_o`, `code_o` and `alo_o` keep their previous values.
- R8: A repeated START in the middle of a byte aborts it and restarts address reception. The frame that follows is handled as a fresh one.
- R9: Pulses on either bus line that last fewer than FILT_LEN system cycles are ignored. They create no START, STOP or bit.
- R10: The acknowledge pull only starts while the filtered clock line is low, and it is released on the falling clock edge that ends the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| prog_mode_i | input | 1 | Programming mode; blocks the acknowledge while 1 |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| upd_o | output | 1 | One-cycle strobe for an accepted data byte |
| psi_o | output | 1 | Power-state flag (data bit 7) |
| code_o | output | 7 | Voltage code (data bits 6:0) |
| alo_o | output | 4 | Address bits 4:1 of the accepting address |

## Verification
The hardest conditions to reach are the aborted frames. One is a repeated START that arrives after a few data bits have already been shifted in. The other is a STOP that cuts the data byte short. In both cases the shift register and bit counter hold partial state that must not leak into a strobe. The bench drives these sequences directly at the bus level and then checks the strobe count and the held outputs. It also places one-cycle data pulses in the clock-high phase, where an unfiltered line would read them as a false START or STOP. These are mixed with random frames that vary the prefix, the direction bit and programming mode.

// File: rtl/svb_pkg.sv
package svb_pkg;

    localparam logic [2:0] ADDR_PREFIX = 3'b110;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_SKIP
    } svb_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } svb_evt_t;

    function automatic logic addr_accept(input logic [7:0] a, input logic prog);
        return (a[7:5] == ADDR_PREFIX) && !a[0] && !prog;
    endfunction

endpackage

// File: rtl/svb_deglitch.sv
module svb_deglitch #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != clean_o) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    clean_o <= sync_q[1];
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/svb_line_events.sv
module svb_line_events
    import svb_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_flt_o,
    output svb_evt_t evt_o
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw, flt, flt_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        svb_deglitch #(.FILT_LEN(FILT_LEN)) u_dg (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .clean_o(flt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= '1;
        else     flt_q <= flt;
    end

    assign scl_flt_o       = flt[0];
    assign evt_o.scl_rise  = flt[0] & ~flt_q[0];
    assign evt_o.scl_fall  = ~flt[0] & flt_q[0];
    assign evt_o.start     = flt[0] & flt_q[0] & flt_q[1] & ~flt[1];
    assign evt_o.stop      = flt[0] & flt_q[0] & ~flt_q[1] & flt[1];
    assign evt_o.sda       = flt[1];
endmodule

// File: rtl/svb_frame_ctl.sv
module svb_frame_ctl
    import svb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  svb_evt_t   evt_i,
    input  logic       prog_i,
    output logic       pull_o,
    output logic       upd_o,
    output logic       psi_o,
    output logic [6:0] code_o,
    output logic [3:0] alo_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    svb_state_t        st_q;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [3:0]        alo_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            sh_q       <= '0;
            cnt_q      <= '0;
            alo_hold_q <= '0;
            pull_o     <= 1'b0;
            upd_o      <= 1'b0;
            psi_o      <= 1'b0;
            code_o     <= '0;
            alo_o      <= '0;
        end else begin
            upd_o <= 1'b0;
            if (evt_i.start) begin
                st_q   <= ST_ADDR;
                cnt_q  <= '0;
                pull_o <= 1'b0;
            end else if (evt_i.stop) begin
                st_q   <= ST_IDLE;
                pull_o <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_DATA: begin
                        if (evt_i.scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], evt_i.sda};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (evt_i.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            cnt_q <= '0;
                            if (st_q == ST_DATA) begin
                                pull_o <= 1'b1;
                                st_q   <= ST_DACK;
                            end else if (addr_accept(sh_q, prog_i)) begin
                                pull_o     <= 1'b1;
                                alo_hold_q <= sh_q[4:1];
                                st_q       <= ST_AACK;
                            end else begin
                                st_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt_i.scl_fall) begin
                            pull_o <= 1'b0;
                            st_q   <= ST_DATA;
                        end
                    end
                    ST_DACK: begin
                        if (evt_i.scl_fall) begin
                            pull_o <= 1'b0;
                            upd_o  <= 1'b1;
                            psi_o  <= sh_q[7];
                            code_o <= sh_q[6:0];
                            alo_o  <= alo_hold_q;
                            st_q   <= ST_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vid_bus_slave.sv
module vid_bus_slave
    import svb_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       prog_mode_i,
    output logic       sda_pull_o,
    output logic       upd_o,
    output logic       psi_o,
    output logic [6:0] code_o,
    output logic [3:0] alo_o
);
    svb_evt_t evt;
    logic     scl_flt;

    svb_line_events #(.FILT_LEN(FILT_LEN)) u_ev (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_flt_o(scl_flt),
        .evt_o    (evt)
    );

    svb_frame_ctl u_fc (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .prog_i(prog_mode_i),
        .pull_o(sda_pull_o),
        .upd_o (upd_o),
        .psi_o (psi_o),
        .code_o(code_o),
        .alo_o (alo_o)
    );
endmodule

// File: rtl/svb_chk.sv
module svb_chk (
    input logic clk,
    input logic rst,
    input logic pull,
    input logic upd,
    input logic prog,
    input logic scl_f
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pull && !upd));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);

    a_r5_strobe_released: assert property (@(posedge clk) disable iff (rst)
        upd |-> !pull);

    a_r4_prog_blocks_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> !$past(prog));

    a_r10_pull_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> !$past(scl_f));
endmodule

bind vid_bus_slave svb_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .pull (sda_pull_o),
    .upd  (upd_o),
    .prog (prog_mode_i),
    .scl_f(scl_flt)
);

// File: tb/sim_vid_bus_slave.sv
`timescale 1ns/1ps
module sim_vid_bus_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, msda = 1'b1, prog = 1'b0;
    logic sda_line;
    logic pull, upd, psi;
    logic [6:0] code;
    logic [3:0] alo;

    int total = 0, bad = 0, strobes = 0;
    logic s_psi; logic [6:0] s_code; logic [3:0] s_alo;

    always #4 clk = ~clk;

    assign sda_line = msda & ~pull;

    vid_bus_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .prog_mode_i(prog), .sda_pull_o(pull), .upd_o(upd),
        .psi_o(psi), .code_o(code), .alo_o(alo)
    );

    always @(negedge clk) if (!rst && upd) begin
        strobes++; s_psi = psi; s_code = code; s_alo = alo;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        msda = 1'b0; wc(2*Q); scl = 1'b0; wc(Q);
    endtask

    task automatic bstop();
        msda = 1'b0; wc(Q); scl = 1'b1; wc(Q); msda = 1'b1; wc(2*Q);
    endtask

    task automatic brestart();
        msda = 1'b1; wc(Q); scl = 1'b1; wc(Q); msda = 1'b0; wc(Q); scl = 1'b0; wc(Q);
    endtask

    task automatic bbit(input logic b, input logic glitch);
        msda = b; wc(Q); scl = 1'b1; wc(Q);
        if (glitch) begin msda = ~b; wc(1); msda = b; wc(Q-1); end
        else wc(Q);
        scl = 1'b0; wc(Q);
    endtask

    task automatic backbit(output logic acked);
        logic lo;
        msda = 1'b1; wc(Q); scl = 1'b1; wc(2); lo = pull; wc(Q-2);
        acked = lo & pull; wc(Q-2); acked = acked & pull; wc(2);
        scl = 1'b0; wc(Q);
    endtask

    task automatic bbyte(input logic [7:0] v, input logic glitch);
        for (int i = 7; i >= 0; i--) bbit(v[i], glitch);
    endtask

    function automatic logic exp_accept(input logic [7:0] a, input logic p);
        return (a[7:5] == 3'b110) && (a[0] == 1'b0) && !p;
    endfunction

    task automatic frame(input logic [7:0] a, input logic [7:0] d, input logic glitch);
        logic ak1, ak2, e;
        int s0;
        e = exp_accept(a, prog);
        s0 = strobes;
        bstart();
        bbyte(a, glitch); backbit(ak1);
        bbyte(d, glitch); backbit(ak2);
        bstop(); wc(20);
        chk(e ? "R2 addr ack" : "R3/R4 addr no-ack", int'(ak1), int'(e));
        chk(e ? "R5 data ack" : "R3/R4 data no-ack", int'(ak2), int'(e));
        chk("R5 strobe count", strobes - s0, e ? 1 : 0);
        if (e) begin
            chk("R5 R6 psi", int'(s_psi), int'(d[7]));
            chk("R5 R6 code", int'(s_code), int'(d[6:0]));
            chk("R5 alo", int'(s_alo), int'(a[4:1]));
            chk("R10 released", int'(pull), 0);
        end
    endtask

    initial begin : wd
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic ak;
        int s0;
        void'($urandom(32'h5EED_0042));
        wc(5); rst = 1'b0; wc(2);
        // R1
        chk("R1 pull", int'(pull), 0);
        chk("R1 upd", int'(upd), 0);
        chk("R1 code", int'(code), 0);
        chk("R1 alo", int'(alo), 0);

        // R2 R5 R6 directed
        frame(8'b1101_0110, 8'hA5, 1'b0);
        frame(8'b1100_0000, 8'h01, 1'b0);
        // R3 wrong prefix and read bit
        frame(8'b1001_0110, 8'h3C, 1'b0);
        frame(8'b1101_0111, 8'h3C, 1'b0);
        // R4 programming mode
        prog = 1'b1; frame(8'b1101_1010, 8'h77, 1'b0); prog = 1'b0;
        // R9 glitches in every high phase
        frame(8'b1101_1110, 8'h5A, 1'b1);
        chk("R9 glitch frame code", int'(code), 8'h5A & 8'h7F);

        // R7 stop mid data byte
        s0 = strobes;
        bstart(); bbyte(8'b1100_0010, 1'b0); backbit(ak);
        bbit(1'b0, 1'b0); bbit(1'b1, 1'b0); bbit(1'b1, 1'b0); bbit(1'b1, 1'b0);
        bstop(); wc(20);
        chk("R7 no strobe", strobes - s0, 0);
        chk("R7 code kept", int'(code), 8'h5A & 8'h7F);
        chk("R7 alo kept", int'(alo), 4'b1111);

        // R8 repeated start mid data byte
        s0 = strobes;
        bstart(); bbyte(8'b1100_1000, 1'b0); backbit(ak);
        bbit(1'b1, 1'b0); bbit(1'b1, 1'b0); bbit(1'b0, 1'b0);
        brestart();
        bbyte(8'b1101_0100, 1'b0); backbit(ak);
        chk("R8 readdress ack", int'(ak), 1);
        bbyte(8'h2E, 1'b0); backbit(ak);
        bstop(); wc(20);
        chk("R8 one strobe", strobes - s0, 1);
        chk("R8 code", int'(s_code), 8'h2E);
        chk("R8 alo", int'(s_alo), 4'b1010);

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, d;
            a = 8'($urandom);
            if ($urandom % 3 != 0) a[7:5] = 3'b110;
            if ($urandom % 3 != 0) a[0] = 1'b0;
            d = 8'($urandom);
            prog = ($urandom % 5 == 0);
            frame(a, d, 1'($urandom % 4 == 0));
        end
        prog = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule